// File: doc/BRIEF.md
# Random-Bit Health Monitor

This block sits beside a true random number generator and keeps watch over one of its internal bit streams. Three candidate streams arrive on plain ports, each carrying a data bit and a valid strobe: the raw sampled stream, the reduced stream and the final output stream. A select input picks which one is watched. On the selected stream two continuous health tests run side by side. A repetition-count test looks for runs of identical bits that are too long. An adaptive-proportion test looks for a window in which one value turns up too often.

Each test has an arm pulse and a disarm pulse that drive its internal active bit. When a test detects a failure, hardware drops that active bit and raises a sticky detect flag, which stays set until its clear input is pulsed. A per-test keep-running policy bit decides whether the detection also produces a one-cycle request to shut the whole generator down. A cutoff of zero is treated as "never fire", so an illegal setting cannot flood the interrupt.

Top module: `trng_health_mon`

## Requirements
- R1: `stream_sel` picks the watched stream: 0 = raw (`raw_bit`/`raw_vld`), 1 = reduced (`red_bit`/`red_vld`), 2 = final (`fin_bit`/`fin_vld`). Only valid samples of the selected stream are counted. Value 3 selects nothing, so neither test can fire.
- R2: The repetition test counts consecutive identical valid bits, with the first bit and every changed bit giving a run of 1. It fires on the sample whose run length equals `rc_cutoff` (1 to 255).
- R3: With `rc_cutoff` equal to 0 the repetition test never fires.
- R4: In the proportion test, the first valid bit of a window becomes its reference. The count of bits equal to the reference, that first bit included, is kept for the window. The test fires on a matching sample that brings the count to `ap_cutoff`. A window lasts `ap_window`+1 valid bits, and the next bit opens a new window.
- R5: With `ap_cutoff` equal to 0 the proportion test never fires.
- R6: After a firing edge, that test's active output reads 0 and its flag reads 1 (`rc_flag`, `ap_flag`). The flag holds until the matching `flag_clr` bit is 1 (bit 0 = repetition, bit 1 = proportion). A detection in the same cycle as a clear leaves the flag set.
- R7: `gen_stop` is 1 for exactly the cycle after a detection by a test whose keep-running bit (`rc_keep_run`, `ap_keep_run`) is 0. Otherwise it is 0.
- R8: An arm pulse sets the test active and restarts its run or window. The sample in the arm cycle is not counted. Arm beats disarm. A disarm pulse clears the active bit without raising the flag.
- R9: An inactive test counts nothing and never fires.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_bit | input | 1 | Raw sampled stream data |
| raw_vld | input | 1 | Raw stream valid |
| red_bit | input | 1 | Reduced stream data |
| red_vld | input | 1 | Reduced stream valid |
| fin_bit | input | 1 | Final stream data |
| fin_vld | input | 1 | Final stream valid |
| stream_sel | input | 2 | Watched stream select |
| rc_arm | input | 1 | Repetition test arm pulse |
| rc_disarm | input | 1 | Repetition test disarm pulse |
| ap_arm | input | 1 | Proportion test arm pulse |
| ap_disarm | input | 1 | Proportion test disarm pulse |
| rc_cutoff | input | 8 | Run length that fails the repetition test |
| ap_cutoff | input | 16 | Occurrence count that fails the proportion test |
| ap_window | input | 16 | Proportion window length minus one |
| rc_keep_run | input | 1 | 1: repetition detection leaves the generator running |
| ap_keep_run | input | 1 | 1: proportion detection leaves the generator running |
| flag_clr | input | 2 | Flag clear, bit 0 repetition, bit 1 proportion |
| rc_active | output | 1 | Repetition test running |
| ap_active | output | 1 | Proportion test running |
| rc_flag | output | 1 | Sticky repetition detect flag |
| ap_flag | output | 1 | Sticky proportion detect flag |
| gen_stop | output | 1 | One-cycle request to stop the generator |

## Verification
The bench sweeps every stream select against small cutoffs and window sizes, including a one-bit window and cutoff 1. In these cases an off-by-one in the window wrap or the run restart moves the firing sample by one bit. That shows up as a flag one cycle early or late, or never. Zero cutoffs and the unused select value are held on long constant streams, where a design that treated 0 as "fire at once" or decoded value 3 would raise a flag. Flag clears are made to collide with detections, and arms are made to collide with disarms and with samples, which exposes a design that prioritised the wrong event or counted the arm-cycle bit. Random keep-running bits catch a stop request that ignores the policy or lasts more than one cycle.

// File: rtl/trng_hm_pkg.sv
package trng_hm_pkg;

    typedef enum logic [1:0] {
        SRC_RAW  = 2'd0,
        SRC_RED  = 2'd1,
        SRC_FIN  = 2'd2,
        SRC_NONE = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic vld;
        logic val;
    } bit_smp_t;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_ARM,
        CMD_DISARM
    } test_cmd_e;

    // Arm has priority over disarm.
    function automatic test_cmd_e decode_cmd(input logic arm, input logic disarm);
        if (arm)
            return CMD_ARM;
        else if (disarm)
            return CMD_DISARM;
        return CMD_IDLE;
    endfunction

endpackage

// File: rtl/trng_hm_src_mux.sv
module trng_hm_src_mux
    import trng_hm_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int SEL_W   = 2
) (
    input  bit_smp_t [NUM_SRC-1:0] srcs,
    input  logic     [SEL_W-1:0]   sel,
    output bit_smp_t               picked
);
    // Unused select codes yield an all-zero (never valid) sample.
    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i))
                picked = srcs[i];
        end
    end
endmodule

// File: rtl/trng_hm_rep_count.sv
module trng_hm_rep_count
    import trng_hm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  test_cmd_e        cmd,
    input  bit_smp_t         smp,
    input  logic [CNT_W-1:0] cutoff,
    output logic             active,
    output logic             fire
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] run_q, run_d;
    logic             prev_q;
    logic             take;

    always_comb begin
        take = active && smp.vld && (cmd == CMD_IDLE);
        if (run_q == '0 || smp.val != prev_q)
            run_d = CNT_ONE;
        else if (run_q == CNT_MAX)
            run_d = run_q;
        else
            run_d = run_q + CNT_ONE;
        fire = take && (cutoff != '0) && (run_d == cutoff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            run_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            case (cmd)
                CMD_ARM: begin
                    active <= 1'b1;
                    run_q  <= '0;
                end
                CMD_DISARM: active <= 1'b0;
                default: begin
                    if (take) begin
                        run_q  <= run_d;
                        prev_q <= smp.val;
                        if (fire)
                            active <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/trng_hm_adapt_prop.sv
module trng_hm_adapt_prop
    import trng_hm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  test_cmd_e        cmd,
    input  bit_smp_t         smp,
    input  logic [CNT_W-1:0] cutoff,
    input  logic [POS_W-1:0] window,
    output logic             active,
    output logic             fire
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

    logic [POS_W-1:0] pos_q, pos_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ref_q;
    logic             first, hit, take;

    always_comb begin
        take  = active && smp.vld && (cmd == CMD_IDLE);
        first = (pos_q == '0);
        hit   = first || (smp.val == ref_q);
        if (first)
            cnt_d = CNT_ONE;
        else if (hit && cnt_q != CNT_MAX)
            cnt_d = cnt_q + CNT_ONE;
        else
            cnt_d = cnt_q;
        pos_d = (pos_q == window) ? '0 : pos_q + POS_ONE;
        fire  = take && hit && (cutoff != '0) && (cnt_d == cutoff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos_q  <= '0;
            cnt_q  <= '0;
            ref_q  <= 1'b0;
        end else begin
            case (cmd)
                CMD_ARM: begin
                    active <= 1'b1;
                    pos_q  <= '0;
                    cnt_q  <= '0;
                end
                CMD_DISARM: active <= 1'b0;
                default: begin
                    if (take) begin
                        pos_q <= pos_d;
                        cnt_q <= cnt_d;
                        if (first)
                            ref_q <= smp.val;
                        if (fire)
                            active <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/trng_health_mon.sv
module trng_health_mon
    import trng_hm_pkg::*;
#(
    parameter int RC_CUT_W = 8,
    parameter int AP_CUT_W = 16,
    parameter int WIN_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                raw_bit,
    input  logic                raw_vld,
    input  logic                red_bit,
    input  logic                red_vld,
    input  logic                fin_bit,
    input  logic                fin_vld,
    input  logic [1:0]          stream_sel,
    input  logic                rc_arm,
    input  logic                rc_disarm,
    input  logic                ap_arm,
    input  logic                ap_disarm,
    input  logic [RC_CUT_W-1:0] rc_cutoff,
    input  logic [AP_CUT_W-1:0] ap_cutoff,
    input  logic [WIN_W-1:0]    ap_window,
    input  logic                rc_keep_run,
    input  logic                ap_keep_run,
    input  logic [1:0]          flag_clr,
    output logic                rc_active,
    output logic                ap_active,
    output logic                rc_flag,
    output logic                ap_flag,
    output logic                gen_stop
);
    localparam int NUM_SRC = 3;
    localparam int NUM_TST = 2;

    bit_smp_t [NUM_SRC-1:0] srcs;
    bit_smp_t               watched;
    logic                   rc_fire, ap_fire;
    logic [NUM_TST-1:0]     fires, keeps, flags;

    assign srcs[SRC_RAW] = '{vld: raw_vld, val: raw_bit};
    assign srcs[SRC_RED] = '{vld: red_vld, val: red_bit};
    assign srcs[SRC_FIN] = '{vld: fin_vld, val: fin_bit};

    trng_hm_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(2)) u_mux (
        .srcs   (srcs),
        .sel    (stream_sel),
        .picked (watched)
    );

    trng_hm_rep_count #(.CNT_W(RC_CUT_W)) u_rep (
        .clk    (clk),
        .rst    (rst),
        .cmd    (decode_cmd(rc_arm, rc_disarm)),
        .smp    (watched),
        .cutoff (rc_cutoff),
        .active (rc_active),
        .fire   (rc_fire)
    );

    trng_hm_adapt_prop #(.CNT_W(AP_CUT_W), .POS_W(WIN_W)) u_prop (
        .clk    (clk),
        .rst    (rst),
        .cmd    (decode_cmd(ap_arm, ap_disarm)),
        .smp    (watched),
        .cutoff (ap_cutoff),
        .window (ap_window),
        .active (ap_active),
        .fire   (ap_fire)
    );

    assign fires = {ap_fire, rc_fire};
    assign keeps = {ap_keep_run, rc_keep_run};

    // Sticky flags: a detection outranks a clear in the same cycle.
    for (genvar t = 0; t < NUM_TST; t++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[t] <= 1'b0;
            else if (fires[t])
                flags[t] <= 1'b1;
            else if (flag_clr[t])
                flags[t] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            gen_stop <= 1'b0;
        else
            gen_stop <= |(fires & ~keeps);
    end

    assign rc_flag = flags[0];
    assign ap_flag = flags[1];
endmodule

// File: rtl/trng_health_mon_chk.sv
module trng_health_mon_chk #(
    parameter int RC_CUT_W = 8,
    parameter int AP_CUT_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          stream_sel,
    input logic [RC_CUT_W-1:0] rc_cutoff,
    input logic [AP_CUT_W-1:0] ap_cutoff,
    input logic [1:0]          flag_clr,
    input logic                rc_keep_run,
    input logic                ap_keep_run,
    input logic                rc_active,
    input logic                ap_active,
    input logic                rc_flag,
    input logic                ap_flag,
    input logic                gen_stop,
    input logic                rc_fire,
    input logic                ap_fire
);
    p_sel_none_r1: assert property (@(posedge clk) disable iff (rst)
        stream_sel == 2'd3 |-> !rc_fire && !ap_fire);

    p_rc_zero_cut_r3: assert property (@(posedge clk) disable iff (rst)
        rc_cutoff == '0 |-> !rc_fire);

    p_ap_zero_cut_r5: assert property (@(posedge clk) disable iff (rst)
        ap_cutoff == '0 |-> !ap_fire);

    p_rc_fire_effect_r6: assert property (@(posedge clk) disable iff (rst)
        rc_fire |=> rc_flag && !rc_active);

    p_ap_fire_effect_r6: assert property (@(posedge clk) disable iff (rst)
        ap_fire |=> ap_flag && !ap_active);

    p_rc_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
        rc_flag && !flag_clr[0] |=> rc_flag);

    p_ap_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ap_flag && !flag_clr[1] |=> ap_flag);

    p_stop_cause_r7: assert property (@(posedge clk) disable iff (rst)
        gen_stop |-> $past((rc_fire && !rc_keep_run) || (ap_fire && !ap_keep_run)));

    p_stop_issue_r7: assert property (@(posedge clk) disable iff (rst)
        (rc_fire && !rc_keep_run) || (ap_fire && !ap_keep_run) |=> gen_stop);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!rc_active |-> !rc_fire) and (!ap_active |-> !ap_fire));
endmodule

bind trng_health_mon trng_health_mon_chk #(
    .RC_CUT_W(RC_CUT_W),
    .AP_CUT_W(AP_CUT_W)
) u_chk (.*);

// File: tb/trng_health_mon_test.sv
module trng_health_mon_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        raw_bit, raw_vld, red_bit, red_vld, fin_bit, fin_vld;
    logic [1:0]  stream_sel;
    logic        rc_arm, rc_disarm, ap_arm, ap_disarm;
    logic [7:0]  rc_cutoff;
    logic [15:0] ap_cutoff, ap_window;
    logic        rc_keep_run, ap_keep_run;
    logic [1:0]  flag_clr;
    logic        rc_active, ap_active, rc_flag, ap_flag, gen_stop;

    always #2.5ns clk = ~clk;

    trng_health_mon uut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference model state, expected values after the next edge
    int m_rc_act, m_rc_run, m_rc_prev;
    int m_ap_act, m_ap_pos, m_ap_ref, m_ap_cnt;
    int m_rc_flag, m_ap_flag, m_gstop;

    logic [31:0] rs = 32'h2468_ace1;

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all(string tag);
        chk(tag, "rc_active", int'(rc_active), m_rc_act);
        chk(tag, "ap_active", int'(ap_active), m_ap_act);
        chk(tag, "rc_flag",   int'(rc_flag),   m_rc_flag);
        chk(tag, "ap_flag",   int'(ap_flag),   m_ap_flag);
        chk(tag, "gen_stop",  int'(gen_stop),  m_gstop);
    endtask

    task automatic model_step();
        int sv, sb, nr, nc, f_rc, f_ap, first, hitv;
        f_rc = 0;
        f_ap = 0;
        case (stream_sel)
            2'd0: begin sv = raw_vld; sb = raw_bit; end
            2'd1: begin sv = red_vld; sb = red_bit; end
            2'd2: begin sv = fin_vld; sb = fin_bit; end
            default: begin sv = 0; sb = 0; end
        endcase
        // repetition test
        if (rc_arm) begin
            m_rc_act = 1; m_rc_run = 0;
        end else if (rc_disarm) begin
            m_rc_act = 0;
        end else if (m_rc_act == 1 && sv == 1) begin
            if (m_rc_run == 0 || sb != m_rc_prev) nr = 1;
            else nr = (m_rc_run == 255) ? 255 : m_rc_run + 1;
            f_rc = (rc_cutoff != 0 && nr == int'(rc_cutoff)) ? 1 : 0;
            m_rc_run = nr;
            m_rc_prev = sb;
            if (f_rc == 1) m_rc_act = 0;
        end
        // proportion test
        if (ap_arm) begin
            m_ap_act = 1; m_ap_pos = 0; m_ap_cnt = 0;
        end else if (ap_disarm) begin
            m_ap_act = 0;
        end else if (m_ap_act == 1 && sv == 1) begin
            first = (m_ap_pos == 0) ? 1 : 0;
            hitv = (first == 1 || sb == m_ap_ref) ? 1 : 0;
            if (first == 1) nc = 1;
            else if (hitv == 1 && m_ap_cnt != 65535) nc = m_ap_cnt + 1;
            else nc = m_ap_cnt;
            f_ap = (hitv == 1 && ap_cutoff != 0 && nc == int'(ap_cutoff)) ? 1 : 0;
            if (first == 1) m_ap_ref = sb;
            m_ap_cnt = nc;
            m_ap_pos = (m_ap_pos == int'(ap_window)) ? 0 : m_ap_pos + 1;
            if (f_ap == 1) m_ap_act = 0;
        end
        m_rc_flag = (f_rc == 1) ? 1 : (flag_clr[0] ? 0 : m_rc_flag);
        m_ap_flag = (f_ap == 1) ? 1 : (flag_clr[1] ? 0 : m_ap_flag);
        m_gstop = ((f_rc == 1 && !rc_keep_run) || (f_ap == 1 && !ap_keep_run)) ? 1 : 0;
    endtask

    task automatic quiet_pulses();
        rc_arm = 0; rc_disarm = 0; ap_arm = 0; ap_disarm = 0; flag_clr = 2'b00;
    endtask

    task automatic cycle(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        cmp_all(tag);
        quiet_pulses();
    endtask

    task automatic all_streams(logic v, logic b);
        raw_vld = v; raw_bit = b;
        red_vld = v; red_bit = b;
        fin_vld = v; fin_bit = b;
    endtask

    task automatic rand_streams();
        logic [31:0] r;
        r = rnd();
        raw_vld = (r[1:0] != 2'b00); raw_bit = r[2];
        red_vld = (r[4:3] != 2'b00); red_bit = r[5];
        fin_vld = (r[7:6] != 2'b00); fin_bit = r[8];
    endtask

    initial begin : watchdog
        #750us;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all R tags) actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int rc_set[5];
        int win_set[4];
        int ap_set[4];
        logic [31:0] r;
        rc_set  = '{0, 1, 2, 3, 5};
        win_set = '{0, 1, 3, 7};
        ap_set  = '{0, 1, 2, 4};

        rst = 1;
        all_streams(0, 0);
        stream_sel = 0; rc_cutoff = 0; ap_cutoff = 0; ap_window = 0;
        rc_keep_run = 1; ap_keep_run = 1;
        quiet_pulses();
        m_rc_act = 0; m_rc_run = 0; m_rc_prev = 0;
        m_ap_act = 0; m_ap_pos = 0; m_ap_ref = 0; m_ap_cnt = 0;
        m_rc_flag = 0; m_ap_flag = 0; m_gstop = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cmp_all("R10");

        // Sweep: select x repetition cutoff x window x proportion cutoff
        for (int s = 0; s < 4; s++)
            for (int ri = 0; ri < 5; ri++)
                for (int wi = 0; wi < 4; wi++)
                    for (int ai = 0; ai < 4; ai++) begin
                        stream_sel = 2'(s);
                        rc_cutoff  = 8'(rc_set[ri]);
                        ap_window  = 16'(win_set[wi]);
                        ap_cutoff  = 16'(ap_set[ai]);
                        rc_arm = 1; ap_arm = 1;
                        rand_streams();
                        cycle("R8");
                        for (int k = 0; k < 40; k++) begin
                            rand_streams();
                            r = rnd();
                            rc_keep_run = r[0];
                            ap_keep_run = r[1];
                            flag_clr = (r[4:2] == 3'b000) ? r[6:5] : 2'b00;
                            rc_arm = (m_rc_act == 0) && (r[8:7] == 2'b00);
                            ap_arm = (m_ap_act == 0) && (r[10:9] == 2'b00);
                            rc_disarm = (r[15:11] == 5'b00000);
                            ap_disarm = (r[20:16] == 5'b00000);
                            cycle("R1 R2 R4 R7 R8");
                        end
                    end

        // Unused select value: constant stream, cutoff 1, nothing may fire
        flag_clr = 2'b11; cycle("R6");
        rc_keep_run = 0; ap_keep_run = 0;
        stream_sel = 2'd3; rc_cutoff = 1; ap_cutoff = 1; ap_window = 0;
        rc_arm = 1; ap_arm = 1;
        all_streams(0, 0);
        cycle("R8");
        for (int k = 0; k < 20; k++) begin
            all_streams(1, 1);
            cycle("R1");
        end
        chk("R1", "rc_flag_sel3", int'(rc_flag), 0);
        chk("R1", "ap_flag_sel3", int'(ap_flag), 0);
        stream_sel = 2'd2;
        cycle("R1");
        chk("R1", "rc_flag_sel2", int'(rc_flag), 1);
        chk("R7", "gen_stop_policy0", int'(gen_stop), 1);
        all_streams(0, 0);
        cycle("R7");
        chk("R7", "gen_stop_one_cycle", int'(gen_stop), 0);

        // Zero cutoffs never fire
        flag_clr = 2'b11; cycle("R6");
        stream_sel = 2'd0; rc_cutoff = 0; ap_cutoff = 0; ap_window = 3;
        rc_arm = 1; ap_arm = 1;
        cycle("R8");
        for (int k = 0; k < 30; k++) begin
            all_streams(1, 0);
            cycle("R3 R5");
        end
        chk("R3", "rc_flag_zero_cut", int'(rc_flag), 0);
        chk("R5", "ap_flag_zero_cut", int'(ap_flag), 0);

        // Inactive tests ignore samples
        rc_disarm = 1; ap_disarm = 1; all_streams(0, 0);
        cycle("R8");
        rc_cutoff = 1; ap_cutoff = 1;
        for (int k = 0; k < 10; k++) begin
            all_streams(1, k[0]);
            cycle("R9");
        end
        chk("R9", "rc_flag_idle", int'(rc_flag), 0);

        // Sticky flag and clear priority
        stream_sel = 2'd1; rc_cutoff = 2; rc_arm = 1; all_streams(0, 0);
        cycle("R8");
        all_streams(1, 1); cycle("R2");
        all_streams(1, 1); cycle("R2");
        chk("R2", "rc_flag_run2", int'(rc_flag), 1);
        all_streams(0, 0);
        for (int k = 0; k < 5; k++) cycle("R6");
        chk("R6", "rc_flag_held", int'(rc_flag), 1);
        flag_clr = 2'b01; cycle("R6");
        chk("R6", "rc_flag_cleared", int'(rc_flag), 0);
        rc_cutoff = 1; rc_arm = 1; cycle("R8");
        all_streams(1, 0); flag_clr = 2'b01; cycle("R6");
        chk("R6", "rc_flag_set_beats_clr", int'(rc_flag), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule